// File: doc/BRIEF.md
# Memory Device Power State Sequencer

This block sits in front of one memory device and decides which of four power levels it runs in: active, standby, nap or powerdown. Reads and writes may only reach the device while it is active and settled. A requester holds `req` high and waits for `grant`. If the device is asleep, the sequencer first runs the wake-up that belongs to its present level, and only then grants. Every step between levels takes a fixed number of controller clock cycles, set by a parameter for each kind of move.

Two idle policies are available. The dynamic policy lowers the device one level at a time, once it has stayed idle for a programmable number of cycles at its present level. The static policy parks the device in one chosen level. It wakes the device only to serve a request and sends it back to that level as soon as no request remains. The present level and a transition flag are brought out so that an outside energy counter can weight time by level.

Top module: `mem_power_ctl`

## Requirements
- R1: After reset the level code is 0 (active), `busyTransition` is low, and `grant` is low while `req` is low. Level codes are 0 active, 1 standby, 2 nap, 3 powerdown.
- R2: While the device is settled in active, `grant` follows `req` in the same cycle, so a request held over consecutive cycles is granted on every one of them.
- R3: A request raised while the device is settled in a low level is granted exactly W+1 cycles later. W is the wake delay of that level: 2 for standby, 12 for nap and 1200 for powerdown by default.
- R4: Under the dynamic policy, a settled level L that is not powerdown steps down to L+1 after T+1 consecutive idle cycles, where T is that level's threshold input. The move takes that step's delay (active to standby 1, standby to nap 1, nap to powerdown 1). Powerdown is held indefinitely.
- R5: Any request clears the idle count, so requests spaced no further apart than the active threshold keep the device in active, with no transition.
- R6: Under the static policy with a non-active target, a settled, idle active device moves directly to the target. This takes the active-exit delay for that target (1 to standby, 8 to nap, 8 to powerdown), and the new code shows 1+delay cycles after reset is released.
- R7: Under the static policy, the first idle cycle after a serviced request starts the return to the target, so `busyTransition` is high in the next cycle.
- R8: A request that arrives during a transition waits until that transition completes, and the wake-up starts only after that.
- R9: `busyTransition` stays high for exactly the delay of the move. During that time the level code keeps showing the level being left, and the code changes only in the cycle where the flag drops.
- R10: Under the static policy with target 0 (active), the device never leaves active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, held until granted |
| policyStatic | input | 1 | 1 selects the static park policy, 0 the dynamic step-down policy |
| staticTarget | input | 2 | Level code the static policy parks in |
| thrActive | input | THR_W | Idle cycles in active before stepping to standby |
| thrStandby | input | THR_W | Idle cycles in standby before stepping to nap |
| thrNap | input | THR_W | Idle cycles in nap before stepping to powerdown |
| grant | output | 1 | Access allowed this cycle |
| stateCode | output | 2 | Present level code |
| busyTransition | output | 1 | A move between levels is in progress |

## Verification
A wrong transition counter load or a wrong delay selection shows up as a grant latency or a level-entry cycle that is off by a fixed amount. It appears on the first wake or step-down after reset, so exact cycle counts are compared for each level. An idle counter that fails to clear, or compares against the wrong threshold, moves `stateCode` away from the expected cycle within a few tens of cycles. A missing return in static mode leaves `busyTransition` low one cycle after the request drops.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

  typedef enum logic [1:0] {
    PS_ACTIVE  = 2'd0,
    PS_STANDBY = 2'd1,
    PS_NAP     = 2'd2,
    PS_DOWN    = 2'd3
  } pwrState_t;

  // Kind of move; selects which delay the datapath loads.
  typedef enum logic [2:0] {
    DK_ACT_SBY = 3'd0,
    DK_ACT_NAP = 3'd1,
    DK_ACT_PD  = 3'd2,
    DK_SBY_NAP = 3'd3,
    DK_NAP_PD  = 3'd4,
    DK_UP_SBY  = 3'd5,
    DK_UP_NAP  = 3'd6,
    DK_UP_PD   = 3'd7
  } delayKind_t;

  typedef struct packed {
    logic       clrIdle;
    logic       incIdle;
    logic       loadTr;
    logic       decTr;
    delayKind_t kind;
  } ctlStrobe_t;

endpackage

// File: rtl/pwr_counters.sv
module pwr_counters
  import pwr_pkg::*;
#(
  parameter int THR_W     = 16,
  parameter int D_ACT_SBY = 1,
  parameter int D_ACT_NAP = 8,
  parameter int D_ACT_PD  = 8,
  parameter int D_SBY_NAP = 1,
  parameter int D_NAP_PD  = 1,
  parameter int D_UP_SBY  = 2,
  parameter int D_UP_NAP  = 12,
  parameter int D_UP_PD   = 1200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctlStrobe_t       strb,
  input  pwrState_t        curState,
  input  logic [THR_W-1:0] thrActive,
  input  logic [THR_W-1:0] thrStandby,
  input  logic [THR_W-1:0] thrNap,
  output logic             idleAtThr,
  output logic             trLast
);

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int MAX_D = maxOf(maxOf(maxOf(D_ACT_SBY, D_ACT_NAP), maxOf(D_ACT_PD, D_SBY_NAP)),
                               maxOf(maxOf(D_NAP_PD, D_UP_SBY), maxOf(D_UP_NAP, D_UP_PD)));
  localparam int TR_W  = $clog2(MAX_D + 1);

  function automatic logic [TR_W-1:0] dlyOf(input delayKind_t k);
    case (k)
      DK_ACT_SBY: return TR_W'(D_ACT_SBY);
      DK_ACT_NAP: return TR_W'(D_ACT_NAP);
      DK_ACT_PD:  return TR_W'(D_ACT_PD);
      DK_SBY_NAP: return TR_W'(D_SBY_NAP);
      DK_NAP_PD:  return TR_W'(D_NAP_PD);
      DK_UP_SBY:  return TR_W'(D_UP_SBY);
      DK_UP_NAP:  return TR_W'(D_UP_NAP);
      default:    return TR_W'(D_UP_PD);
    endcase
  endfunction

  logic [THR_W-1:0] idleCnt;
  logic [TR_W-1:0]  trCnt;
  logic [THR_W-1:0] thrSel;

  always_comb begin
    case (curState)
      PS_ACTIVE:  thrSel = thrActive;
      PS_STANDBY: thrSel = thrStandby;
      default:    thrSel = thrNap;
    endcase
  end

  assign idleAtThr = (curState != PS_DOWN) && (idleCnt == thrSel);
  assign trLast    = (trCnt == TR_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idleCnt <= '0;
    end else if (strb.clrIdle) begin
      idleCnt <= '0;
    end else if (strb.incIdle) begin
      idleCnt <= idleCnt + THR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trCnt <= '0;
    end else if (strb.loadTr) begin
      trCnt <= dlyOf(strb.kind);
    end else if (strb.decTr) begin
      trCnt <= trCnt - TR_W'(1);
    end
  end

  // R9
  dec_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.decTr |-> (trCnt != '0));

  // R9
  tr_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.decTr && !trLast) |=> strb.decTr);

endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
  import pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic       policyStatic,
  input  logic [1:0] staticTarget,
  input  logic       idleAtThr,
  input  logic       trLast,
  output ctlStrobe_t strb,
  output pwrState_t  curState,
  output logic       busy,
  output logic       grant
);

  pwrState_t curNext, destState, destNext;
  logic      busyNext;
  pwrState_t parkState;

  assign parkState = pwrState_t'(staticTarget);

  function automatic delayKind_t stepKind(input pwrState_t s);
    case (s)
      PS_ACTIVE:  return DK_ACT_SBY;
      PS_STANDBY: return DK_SBY_NAP;
      default:    return DK_NAP_PD;
    endcase
  endfunction

  function automatic delayKind_t wakeKind(input pwrState_t s);
    case (s)
      PS_STANDBY: return DK_UP_SBY;
      PS_NAP:     return DK_UP_NAP;
      default:    return DK_UP_PD;
    endcase
  endfunction

  function automatic delayKind_t exitKind(input pwrState_t s);
    case (s)
      PS_STANDBY: return DK_ACT_SBY;
      PS_NAP:     return DK_ACT_NAP;
      default:    return DK_ACT_PD;
    endcase
  endfunction

  always_comb begin
    strb.clrIdle = 1'b0;
    strb.incIdle = 1'b0;
    strb.loadTr  = 1'b0;
    strb.decTr   = 1'b0;
    strb.kind    = DK_ACT_SBY;
    curNext      = curState;
    busyNext     = busy;
    destNext     = destState;
    if (busy) begin
      strb.decTr = 1'b1;
      if (trLast) begin
        curNext      = destState;
        busyNext     = 1'b0;
        strb.clrIdle = 1'b1;
      end
    end else if (req) begin
      strb.clrIdle = 1'b1;
      if (curState != PS_ACTIVE) begin
        strb.loadTr = 1'b1;
        strb.kind   = wakeKind(curState);
        destNext    = PS_ACTIVE;
        busyNext    = 1'b1;
      end
    end else if (policyStatic) begin
      strb.clrIdle = 1'b1;
      if (curState != parkState) begin
        strb.loadTr = 1'b1;
        busyNext    = 1'b1;
        if (curState == PS_ACTIVE) begin
          strb.kind = exitKind(parkState);
          destNext  = parkState;
        end else if (curState < parkState) begin
          strb.kind = stepKind(curState);
          destNext  = pwrState_t'(curState + 2'd1);
        end else begin
          strb.kind = wakeKind(curState);
          destNext  = PS_ACTIVE;
        end
      end
    end else if (curState != PS_DOWN) begin
      if (idleAtThr) begin
        strb.loadTr = 1'b1;
        strb.kind   = stepKind(curState);
        destNext    = pwrState_t'(curState + 2'd1);
        busyNext    = 1'b1;
      end else begin
        strb.incIdle = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curState  <= PS_ACTIVE;
      destState <= PS_ACTIVE;
      busy      <= 1'b0;
    end else begin
      curState  <= curNext;
      destState <= destNext;
      busy      <= busyNext;
    end
  end

  assign grant = req && !busy && (curState == PS_ACTIVE);

  // R9
  state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (curState != $past(curState)) |-> ($past(busy) && !busy));

  // R3
  wake_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (curState < $past(curState)) |-> (curState == PS_ACTIVE));

  // R7
  static_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (policyStatic && staticTarget != 2'd0 && $past(grant) && !req) |=> busy);

endmodule

// File: rtl/mem_power_ctl.sv
module mem_power_ctl
  import pwr_pkg::*;
#(
  parameter int THR_W     = 16,
  parameter int D_ACT_SBY = 1,
  parameter int D_ACT_NAP = 8,
  parameter int D_ACT_PD  = 8,
  parameter int D_SBY_NAP = 1,
  parameter int D_NAP_PD  = 1,
  parameter int D_UP_SBY  = 2,
  parameter int D_UP_NAP  = 12,
  parameter int D_UP_PD   = 1200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             policyStatic,
  input  logic [1:0]       staticTarget,
  input  logic [THR_W-1:0] thrActive,
  input  logic [THR_W-1:0] thrStandby,
  input  logic [THR_W-1:0] thrNap,
  output logic             grant,
  output logic [1:0]       stateCode,
  output logic             busyTransition
);

  ctlStrobe_t strb;
  pwrState_t  curState;
  logic       busy, idleAtThr, trLast;

  pwr_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req(req), .policyStatic(policyStatic),
    .staticTarget(staticTarget), .idleAtThr(idleAtThr), .trLast(trLast),
    .strb(strb), .curState(curState), .busy(busy), .grant(grant)
  );

  pwr_counters #(
    .THR_W(THR_W), .D_ACT_SBY(D_ACT_SBY), .D_ACT_NAP(D_ACT_NAP), .D_ACT_PD(D_ACT_PD),
    .D_SBY_NAP(D_SBY_NAP), .D_NAP_PD(D_NAP_PD), .D_UP_SBY(D_UP_SBY),
    .D_UP_NAP(D_UP_NAP), .D_UP_PD(D_UP_PD)
  ) u_cnt (
    .clk(clk), .rst_n(rst_n), .strb(strb), .curState(curState),
    .thrActive(thrActive), .thrStandby(thrStandby), .thrNap(thrNap),
    .idleAtThr(idleAtThr), .trLast(trLast)
  );

  assign stateCode      = curState;
  assign busyTransition = busy;

endmodule

// File: tb/tb_mem_power_ctl.sv
`timescale 1ns/1ps
module tb_mem_power_ctl;

  localparam int THR_W = 16;
  localparam int DA_S = 1, DA_N = 8, DA_P = 8, DS_N = 1, DN_P = 1;
  localparam int DU_S = 2, DU_N = 12, DU_P = 1200;

  // target, cycles until code changes after reset release (-1: never), wake latency
  localparam int NV = 4;
  localparam int VEC [NV][3] = '{
    '{1, 1 + DA_S, DU_S + 1},
    '{2, 1 + DA_N, DU_N + 1},
    '{3, 1 + DA_P, DU_P + 1},
    '{0, -1,       0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic policyStatic = 1'b0;
  logic [1:0] staticTarget = 2'd0;
  logic [THR_W-1:0] thrActive = '0, thrStandby = '0, thrNap = '0;
  logic grant, busyTransition;
  logic [1:0] stateCode;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  mem_power_ctl #(
    .THR_W(THR_W), .D_ACT_SBY(DA_S), .D_ACT_NAP(DA_N), .D_ACT_PD(DA_P),
    .D_SBY_NAP(DS_N), .D_NAP_PD(DN_P), .D_UP_SBY(DU_S), .D_UP_NAP(DU_N), .D_UP_PD(DU_P)
  ) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .policyStatic(policyStatic),
    .staticTarget(staticTarget), .thrActive(thrActive), .thrStandby(thrStandby),
    .thrNap(thrNap), .grant(grant), .stateCode(stateCode), .busyTransition(busyTransition)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doReset();
    rst_n = 1'b0;
    req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic waitGrant(output int lat);
    lat = 0;
    #1;
    while (!grant && lat < 5000) begin
      @(negedge clk);
      #1;
      lat++;
    end
  endtask

  initial begin
    int lat, c, allOk;
    // R1 reset state
    policyStatic = 1'b0;
    thrActive = 16'd5; thrStandby = 16'd3; thrNap = 16'd4;
    doReset();
    #1;
    chk("R1 code", stateCode, 0);
    chk("R1 busy", busyTransition, 0);
    chk("R1 grant", grant, 0);

    // Table: static policy per target
    for (int i = 0; i < NV; i++) begin
      policyStatic = 1'b1;
      staticTarget = 2'(VEC[i][0]);
      doReset();
      if (VEC[i][1] > 0) begin
        c = 0;
        while (stateCode != 2'(VEC[i][0]) && c < 3000) begin
          @(negedge clk);
          c++;
        end
        chk("R6 entry cycle", c, VEC[i][1]);
      end else begin
        allOk = 1;
        for (int k = 0; k < 12; k++) begin
          @(negedge clk);
          if (stateCode != 2'd0 || busyTransition) allOk = 0;
        end
        chk("R10 stays active", allOk, 1);
      end
      repeat (3) @(negedge clk);
      req = 1'b1;
      waitGrant(lat);
      chk("R3 wake latency", lat, VEC[i][2]);
      allOk = 1;
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        #1;
        if (!grant) allOk = 0;
      end
      chk("R2 back-to-back grant", allOk, 1);
      @(negedge clk);
      req = 1'b0;
      @(negedge clk);
      chk("R7 return starts", busyTransition, (VEC[i][0] != 0) ? 1 : 0);
    end

    // R4 / R9 dynamic step-down timing
    policyStatic = 1'b0;
    thrActive = 16'd5; thrStandby = 16'd3; thrNap = 16'd4;
    doReset();
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      if (k == 6) begin
        chk("R9 busy during step", busyTransition, 1);
        chk("R9 code holds departing level", stateCode, 0);
      end
      if (k == 7) begin
        chk("R4 standby entry", stateCode, 1);
        chk("R9 busy drops with code", busyTransition, 0);
      end
      if (k == 12) chk("R4 nap entry", stateCode, 2);
      if (k == 17) chk("R4 still nap", stateCode, 2);
      if (k == 18) chk("R4 powerdown entry", stateCode, 3);
    end
    repeat (30) @(negedge clk);
    chk("R4 powerdown held", stateCode, 3);
    req = 1'b1;
    waitGrant(lat);
    chk("R3 dynamic wake from powerdown", lat, DU_P + 1);
    @(negedge clk);
    req = 1'b0;

    // R5 periodic requests clear the idle count
    doReset();
    allOk = 1;
    for (int k = 1; k <= 40; k++) begin
      req = ((k % 5) == 4);
      @(negedge clk);
      if (stateCode != 2'd0 || busyTransition) allOk = 0;
    end
    req = 1'b0;
    chk("R5 stays active", allOk, 1);

    // R8 request during transition waits for it to finish
    policyStatic = 1'b1;
    staticTarget = 2'd2;
    doReset();
    c = 0;
    while (!busyTransition && c < 100) begin
      @(negedge clk);
      c++;
    end
    chk("R8 transition started", c, 1);
    req = 1'b1;
    waitGrant(lat);
    chk("R8 latency", lat, (DA_N - 1) + DU_N + 2);
    @(negedge clk);
    req = 1'b0;

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule